// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two unsigned or two's-complement operands plus an incoming carry using purely combinational logic. The operand is split into equal-width groups. Inside each group, per-bit generate and propagate terms feed sum-of-products equations that give every internal carry directly. The carry entering a group is not rippled from its lower neighbour. A second lookahead stage builds it from the group-level generate and propagate terms and the incoming carry.

The second stage uses the same equation form as the groups. It also yields the carry-out and a whole-word generate/propagate pair. That pair lets a wider adder use this block as one group of a further lookahead level.

With the default parameters the block is 16 bits wide, made of four 4-bit groups. Other group widths and group counts can be set through parameters.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `op_a + op_b + carry_in`, where WIDTH = GROUP_W * GROUPS (16 by default).
- R2: `carry_out` equals bit WIDTH of the (WIDTH+1)-bit sum `op_a + op_b + carry_in`.
- R3: `blk_prop` is 1 exactly when every bit position has differing operand bits, that is, when `op_a ^ op_b` is all ones.
- R4: `blk_gen` is 1 exactly when `op_a + op_b` alone, with no carry-in, reaches 2^WIDTH. Its value does not depend on `carry_in`.
- R5: `carry_out` equals `blk_gen | (blk_prop & carry_in)`, so a higher lookahead level can rebuild the carry from the pair.
- R6: `blk_gen` and `blk_prop` are never 1 at the same time.
- R7: When every bit propagates, the carry-in passes to every position. `sum_o` is then all ones for `carry_in` = 0, and all zeros with `carry_out` = 1 for `carry_in` = 1.
- R8: R1 to R4 hold in a configuration of one group of four bits and in a configuration of two groups of two bits, over every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| blk_gen | output | 1 | Whole-word generate, for cascading |
| blk_prop | output | 1 | Whole-word propagate, for cascading |

## Verification
The bound checker tests every input combination as it appears against an arithmetic reference. It checks the sum and carry-out, that the generate/propagate pair rebuilds the carry-out, that the pair is never both set, and that propagate means all operand bits differ.

Some behaviour only the bench's scenarios show. One is the carry passing through every position when all bits propagate, as in R7. The others are the exhaustive sweeps of the small configurations and the corner operands at full width, which prove the groups are wired to the right second-level carries.

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4
) (
  input  logic [GROUP_W*GROUPS-1:0] op_a,
  input  logic [GROUP_W*GROUPS-1:0] op_b,
  input  logic                      carry_in,
  output logic [GROUP_W*GROUPS-1:0] sum_o,
  output logic                      carry_out,
  output logic                      blk_gen,
  output logic                      blk_prop
);
  localparam int WIDTH = GROUP_W * GROUPS;
  localparam int LN    = (GROUP_W > GROUPS) ? GROUP_W : GROUPS;

  function automatic logic [LN:0] lookahead(input logic [LN-1:0] g,
                                            input logic [LN-1:0] p,
                                            input logic c0,
                                            input int n);
    logic [LN:0] c;
    logic        term;
    c    = '0;
    c[0] = c0;
    for (int i = 0; i < LN; i++) begin
      if (i < n) begin
        term = c0;
        for (int k = 0; k < LN; k++) if (k <= i) term = term & p[k];
        c[i+1] = term;
        for (int j = 0; j < LN; j++) begin
          if (j <= i) begin
            term = g[j];
            for (int k = 0; k < LN; k++) if (k > j && k <= i) term = term & p[k];
            c[i+1] = c[i+1] | term;
          end
        end
      end
    end
    return c;
  endfunction

  logic [GROUPS-1:0] grp_g, grp_p;
  logic [LN:0]       grp_c;
  logic [LN:0]       top_nc;
  logic [LN-1:0]     grp_g_x, grp_p_x;

  assign grp_g_x = LN'(grp_g);
  assign grp_p_x = LN'(grp_p);

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    logic [GROUP_W-1:0] bg, bp;
    logic [LN:0]        cc, gc;
    assign bg = op_a[gi*GROUP_W +: GROUP_W] & op_b[gi*GROUP_W +: GROUP_W];
    assign bp = op_a[gi*GROUP_W +: GROUP_W] ^ op_b[gi*GROUP_W +: GROUP_W];
    assign cc = lookahead(LN'(bg), LN'(bp), grp_c[gi], GROUP_W);
    assign gc = lookahead(LN'(bg), LN'(bp), 1'b0, GROUP_W);
    assign grp_g[gi] = gc[GROUP_W];
    assign grp_p[gi] = &bp;
    assign sum_o[gi*GROUP_W +: GROUP_W] = bp ^ cc[GROUP_W-1:0];
  end

  assign grp_c     = lookahead(grp_g_x, grp_p_x, carry_in, GROUPS);
  assign top_nc    = lookahead(grp_g_x, grp_p_x, 1'b0, GROUPS);
  assign carry_out = grp_c[GROUPS];
  assign blk_gen   = top_nc[GROUPS];
  assign blk_prop  = &grp_p;
endmodule

module lookahead_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic [W-1:0] sum_o,
  input logic         carry_out,
  input logic         blk_gen,
  input logic         blk_prop
);
  logic [W:0] ref_full, ref_nc;
  logic       known;
  assign ref_full = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign ref_nc   = {1'b0, op_a} + {1'b0, op_b};
  assign known    = !$isunknown({op_a, op_b, carry_in});

  always_comb begin
    if (known) begin
      // R1
      sum_value_chk: assert (sum_o == ref_full[W-1:0]);
      // R2
      carry_value_chk: assert (carry_out == ref_full[W]);
      // R3
      prop_all_differ_chk: assert (blk_prop == &(op_a ^ op_b));
      // R4
      gen_no_cin_chk: assert (blk_gen == ref_nc[W]);
      // R5
      carry_rebuild_chk: assert (carry_out == (blk_gen | (blk_prop & carry_in)));
      // R6
      gen_prop_excl_chk: assert (!(blk_gen && blk_prop));
    end
  end
endmodule

bind lookahead_adder lookahead_adder_chk #(.W(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sum_o(sum_o),
  .carry_out(carry_out), .blk_gen(blk_gen), .blk_prop(blk_prop)
);

// File: tb/lookahead_adder_tb.sv
module lookahead_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic         ci = 1'b0;
  logic [W-1:0] s;
  logic         co, gg, pp;

  logic [3:0] sa = '0, sb = '0;
  logic       sci = 1'b0;
  logic [3:0] s1, s2;
  logic       co1, g1, p1, co2, g2, p2;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  lookahead_adder u_dut (.op_a(a), .op_b(b), .carry_in(ci), .sum_o(s),
                         .carry_out(co), .blk_gen(gg), .blk_prop(pp));
  lookahead_adder #(.GROUP_W(4), .GROUPS(1)) u_one (.op_a(sa), .op_b(sb), .carry_in(sci),
                         .sum_o(s1), .carry_out(co1), .blk_gen(g1), .blk_prop(p1));
  lookahead_adder #(.GROUP_W(2), .GROUPS(2)) u_two (.op_a(sa), .op_b(sb), .carry_in(sci),
                         .sum_o(s2), .carry_out(co2), .blk_gen(g2), .blk_prop(p2));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h", req, a, b, ci, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    logic [W:0] full, nc;
    @(negedge clk);
    a = va; b = vb; ci = vc;
    #(CLK_PERIOD/4);
    full = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    nc   = {1'b0, va} + {1'b0, vb};
    check(s == full[W-1:0], "R1 sum", 32'(s), 32'(full[W-1:0]));
    check(co == full[W], "R2 carry_out", 32'(co), 32'(full[W]));
    check(pp == &(va ^ vb), "R3 propagate", 32'(pp), 32'(&(va ^ vb)));
    check(gg == nc[W], "R4 generate", 32'(gg), 32'(nc[W]));
    check(co == (gg | (pp & vc)), "R5 carry rebuild", 32'(co), 32'(gg | (pp & vc)));
    check(!(gg && pp), "R6 exclusive", 32'({gg, pp}), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    check(s == '0 && co == 1'b0 && gg == 1'b0 && pp == 1'b0, "R1 reset zero inputs",
          32'({co, gg, pp, s}), 32'h0);
    rst_n = 1'b1;

    // R7: all-propagate corners
    apply(16'hAAAA, 16'h5555, 1'b0);
    check(s == 16'hFFFF && co == 1'b0, "R7 propagate cin0", 32'({co, s}), 32'h0FFFF);
    apply(16'hAAAA, 16'h5555, 1'b1);
    check(s == 16'h0000 && co == 1'b1, "R7 propagate cin1", 32'({co, s}), 32'h10000);
    apply(16'h0000, 16'hFFFF, 1'b1);
    check(s == 16'h0000 && co == 1'b1, "R7 propagate cin1 b", 32'({co, s}), 32'h10000);

    apply(16'h0000, 16'h0000, 1'b0);
    apply(16'hFFFF, 16'h0001, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h7FFF, 16'h0001, 1'b0);
    apply(16'h0FFF, 16'h0000, 1'b1);
    apply(16'h00FF, 16'h0001, 1'b0);
    apply(16'h000F, 16'h0001, 1'b0);
    for (int i = 0; i < 16; i++) apply(16'hFFFF >> i, 16'h0001 << i, 1'b0);
    for (int i = 0; i < 3000; i++) apply(W'($urandom), W'($urandom), 1'($urandom));

    // R8: exhaustive sweeps over small configurations
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int c = 0; c < 2; c++) begin
          logic [4:0] f, q;
          @(negedge clk);
          sa = 4'(x); sb = 4'(y); sci = 1'(c);
          #(CLK_PERIOD/4);
          f = 5'(x) + 5'(y) + 5'(c);
          q = 5'(x) + 5'(y);
          check({co1, s1} == f, "R8 one group sum", 32'({co1, s1}), 32'(f));
          check({co2, s2} == f, "R8 two groups sum", 32'({co2, s2}), 32'(f));
          check(g1 == q[4] && g2 == q[4], "R8 generate", 32'({g1, g2}), 32'({q[4], q[4]}));
          check(p1 == &(sa ^ sb) && p2 == &(sa ^ sb), "R8 propagate", 32'({p1, p2}),
                32'({&(sa ^ sb), &(sa ^ sb)}));
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule